// File: doc/BRIEF.md
# Machine Clock Source Switch Controller

This block decides which of two clocks drives the processor core: the raw main oscillator clock or a PLL-multiplied clock with a factor from one to four. Software writes a source-request bit and a two-bit multiplier code. A separate read-only indication bit reports which source is really in use. The two bits are decoupled: a switch to the PLL only takes effect after a stabilization wait, and a switch back to main only takes effect on a synchronization point where the two clocks line up.

The stabilization wait is an internal cycle counter of programmable length that runs while the PLL is requested. The synchronization point comes in as a strobe from an external free-running divider. A standby reset or a watchdog reset forces the request back to main. The outputs drive a glitch-free clock multiplexer and the PLL divider setting. Neither the analog PLL nor the gating cells are modelled here.

Top module: `clk_src_switch`

## Requirements
- R1: During and after reset the request bit reads 1 (main), the indication bit reads 1, the PLL select is 0, and both the multiplier code and the active multiplier are 0.
- R2: When the request bit is 0 while on main, the block waits STAB_CYCLES cycles. During that time the PLL select stays 0 and the indication bit stays 1.
- R3: When the wait ends, the PLL select becomes 1 and the indication bit becomes 0. The active multiplier takes the code held at that moment, where code 0, 1, 2 and 3 mean a factor of 1, 2, 3 and 4.
- R4: When the request bit is 1 while on the PLL, the PLL select stays 1 and the indication bit stays 0 until a cycle in which the sync strobe is high. After that clock edge both return to main.
- R5: A standby reset pulse or a watchdog reset pulse sets the request bit to 1 on the next edge. It takes priority over a software write in the same cycle, and it starts the return to main.
- R6: A multiplier write while the PLL select is 1 leaves the active multiplier unchanged. The new code takes effect at the next entry into PLL operation.
- R7: If the request bit goes back to 1 before the wait ends, the wait is abandoned and the block returns to main without ever selecting the PLL.
- R8: The indication data bit on the write port has no effect on the indication output.
- R9: The PLL select rises only one edge after a cycle in which the wait ended. It falls only one edge after a cycle in which the sync strobe was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| wr_en_i | input | 1 | Write strobe for the control register |
| wr_sel_i | input | 1 | Request bit to write (1 = main, 0 = PLL) |
| wr_mult_i | input | MULT_W | Multiplier code to write |
| wr_ind_i | input | 1 | Indication bit data on the write port, ignored |
| standby_rst_i | input | 1 | Standby reset event pulse |
| wdt_rst_i | input | 1 | Watchdog reset event pulse |
| sync_stb_i | input | 1 | PLL/main alignment point strobe |
| clk_sel_pll_o | output | 1 | Clock mux select, 1 = PLL clock |
| act_mult_o | output | MULT_W | Multiplier code in use by the PLL path |
| ind_o | output | 1 | Indication bit, 1 = main clock in use |
| sel_o | output | 1 | Read-back of the request bit |
| mult_code_o | output | MULT_W | Read-back of the written multiplier code |

## Verification
On every cycle the assertions check the following: the mux select moves only after a wait-done cycle or a strobe cycle, the select holds while a return is pending without a strobe, an abort during the wait goes straight to main, the active multiplier is frozen while on the PLL, a reset event forces the request bit, and a write cannot move the indication bit. Other properties need the bench's scenarios and its cycle-accurate reference model. These are the exact length of the wait, the mapping of every multiplier code, the latching of a code written during PLL operation at the following entry, and the ordering of write and reset events against one another under random stimulus.

// File: rtl/clksw_pkg.sv
package clksw_pkg;
  typedef enum logic [1:0] {
    CS_MAIN = 2'd0,
    CS_STAB = 2'd1,
    CS_PLL  = 2'd2,
    CS_RET  = 2'd3
  } csw_state_e;
endpackage

// File: rtl/clksw_ctrl_reg.sv
module clksw_ctrl_reg #(
  parameter int MULT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [MULT_W-1:0] wr_mult,
  input  logic              force_main,
  output logic              sel_q,
  output logic [MULT_W-1:0] code_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q  <= 1'b1;
      code_q <= '0;
    end else begin
      if (force_main)  sel_q <= 1'b1;
      else if (wr_en)  sel_q <= wr_sel;
      if (wr_en)       code_q <= wr_mult;
    end
  end

  // R5
  force_main_chk: assert property (@(posedge clk) disable iff (rst)
    force_main |=> sel_q);
endmodule

// File: rtl/clksw_stab_timer.sv
module clksw_stab_timer #(
  parameter int STAB_CYCLES = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic done
);
  localparam int CNT_W = $clog2(STAB_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(STAB_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !run) cnt_q <= '0;
    else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign done = run && (cnt_q == LAST);
endmodule

// File: rtl/clksw_fsm.sv
module clksw_fsm
  import clksw_pkg::*;
#(
  parameter int MULT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_req,
  input  logic              stab_done,
  input  logic              sync_stb,
  input  logic [MULT_W-1:0] code,
  output logic              stab_run,
  output logic              ret_pend,
  output logic              pll_sel,
  output logic [MULT_W-1:0] act_mult
);
  csw_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      CS_MAIN: if (!sel_req) state_d = CS_STAB;
      CS_STAB: begin
        if (sel_req)        state_d = CS_MAIN;
        else if (stab_done) state_d = CS_PLL;
      end
      CS_PLL:  if (sel_req)  state_d = CS_RET;
      CS_RET:  if (sync_stb) state_d = CS_MAIN;
      default: state_d = CS_MAIN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= CS_MAIN;
      pll_sel  <= 1'b0;
      act_mult <= '0;
    end else begin
      state_q <= state_d;
      pll_sel <= (state_d == CS_PLL) || (state_d == CS_RET);
      if (state_q == CS_STAB && state_d == CS_PLL) act_mult <= code;
    end
  end

  assign stab_run = (state_q == CS_STAB);
  assign ret_pend = (state_q == CS_RET);

  // R9
  pll_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pll_sel) |-> $past(stab_done));
  // R9
  pll_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(pll_sel) |-> $past(sync_stb));
  // R4
  ret_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == CS_RET && !sync_stb) |=> pll_sel);
  // R7
  abort_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == CS_STAB && sel_req) |=> (state_q == CS_MAIN && !pll_sel));
  // R2
  wait_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == CS_STAB && !sel_req && !stab_done) |=> (state_q == CS_STAB && !pll_sel));
  // R6
  act_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == CS_PLL || state_q == CS_RET) |=> $stable(act_mult));
endmodule

// File: rtl/clk_src_switch.sv
module clk_src_switch #(
  parameter int STAB_CYCLES = 16,
  parameter int MULT_W      = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_i,
  input  logic              wr_sel_i,
  input  logic [MULT_W-1:0] wr_mult_i,
  input  logic              wr_ind_i,
  input  logic              standby_rst_i,
  input  logic              wdt_rst_i,
  input  logic              sync_stb_i,
  output logic              clk_sel_pll_o,
  output logic [MULT_W-1:0] act_mult_o,
  output logic              ind_o,
  output logic              sel_o,
  output logic [MULT_W-1:0] mult_code_o
);
  logic              sel_q;
  logic [MULT_W-1:0] code_q;
  logic              stab_run, stab_done, ret_pend, pll_sel;

  clksw_ctrl_reg #(.MULT_W(MULT_W)) u_reg (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en_i),
    .wr_sel     (wr_sel_i),
    .wr_mult    (wr_mult_i),
    .force_main (standby_rst_i | wdt_rst_i),
    .sel_q      (sel_q),
    .code_q     (code_q)
  );

  clksw_stab_timer #(.STAB_CYCLES(STAB_CYCLES)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .run  (stab_run),
    .done (stab_done)
  );

  clksw_fsm #(.MULT_W(MULT_W)) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .sel_req   (sel_q),
    .stab_done (stab_done),
    .sync_stb  (sync_stb_i),
    .code      (code_q),
    .stab_run  (stab_run),
    .ret_pend  (ret_pend),
    .pll_sel   (pll_sel),
    .act_mult  (act_mult_o)
  );

  assign clk_sel_pll_o = pll_sel;
  assign ind_o         = ~pll_sel;
  assign sel_o         = sel_q;
  assign mult_code_o   = code_q;

  // R8
  ind_ro_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && (wr_ind_i != ind_o) && !stab_done && !(ret_pend && sync_stb_i))
      |=> (ind_o == $past(ind_o)));
endmodule

// File: tb/clk_src_switch_tb_top.sv
module clk_src_switch_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int STAB = 12;
  localparam int WD_LIMIT = 100000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 0, wr_sel = 1, wr_ind = 0, sby = 0, wdt = 0, man_sync = 0, free_en = 0;
  logic [1:0] wr_mult = 0;
  logic sync_stb;
  logic clk_sel_pll, ind, sel;
  logic [1:0] act_mult, mult_code;
  int div_cnt = 0;
  int checks = 0, fails = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign sync_stb = man_sync | (free_en && div_cnt == 0);
  always @(posedge clk) div_cnt <= (div_cnt == 6) ? 0 : div_cnt + 1;

  clk_src_switch #(.STAB_CYCLES(STAB), .MULT_W(2)) dut_i (
    .clk(clk), .rst(rst), .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_mult_i(wr_mult),
    .wr_ind_i(wr_ind), .standby_rst_i(sby), .wdt_rst_i(wdt), .sync_stb_i(sync_stb),
    .clk_sel_pll_o(clk_sel_pll), .act_mult_o(act_mult), .ind_o(ind), .sel_o(sel),
    .mult_code_o(mult_code)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: 0 main, 1 waiting, 2 pll, 3 return pending
  int m_st = 0, m_cnt = 0, m_act = 0, m_code = 0;
  bit m_sel = 1, gate_prev = 0, prev_pll = 0;
  string st_tag[4] = '{"R1", "R2", "R3", "R4"};

  always @(posedge clk) begin
    int nst;
    gate_prev = (m_st == 1 && m_cnt == STAB - 1) || sync_stb;
    if (rst) begin
      m_st = 0; m_cnt = 0; m_act = 0; m_code = 0; m_sel = 1;
    end else begin
      nst = m_st;
      case (m_st)
        0: begin if (!m_sel) nst = 1; m_cnt = 0; end
        1: begin
          if (m_sel) nst = 0;
          else if (m_cnt == STAB - 1) begin nst = 2; m_act = m_code; end
          m_cnt = (nst == 1) ? m_cnt + 1 : 0;
        end
        2: if (m_sel) nst = 3;
        default: if (sync_stb) nst = 0;
      endcase
      if (sby || wdt) m_sel = 1;
      else if (wr_en) m_sel = wr_sel;
      if (wr_en) m_code = int'(wr_mult);
      m_st = nst;
    end
  end

  always @(negedge clk) begin
    bit m_pll;
    cyc++;
    if (!rst) begin
      m_pll = (m_st >= 2);
      chk(clk_sel_pll == m_pll, {st_tag[m_st], " mux select"}, clk_sel_pll, m_pll);
      chk(ind == !m_pll, {st_tag[m_st], "/R8 indication"}, ind, !m_pll);
      chk(sel == m_sel, "R5 request bit", sel, m_sel);
      chk(act_mult == m_act[1:0], "R6 active multiplier", act_mult, m_act);
      chk(mult_code == m_code[1:0], "R6 code readback", mult_code, m_code);
      if (clk_sel_pll != prev_pll)
        chk(gate_prev, "R9 select moved without wait end or strobe", clk_sel_pll, prev_pll);
      prev_pll = clk_sel_pll;
    end
    if (cyc > WD_LIMIT) begin
      chk(1'b0, "watchdog expired", cyc, WD_LIMIT);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input bit s, input int m, input bit i);
    @(negedge clk);
    wr_en = 1; wr_sel = s; wr_mult = m[1:0]; wr_ind = i;
    @(negedge clk);
    wr_en = 0; wr_ind = 0;
  endtask

  task automatic strobe();
    man_sync = 1; tick(1); man_sync = 0;
  endtask

  task automatic go_pll(input int code);
    wr(0, code, 0);
    tick(3);
    chk(clk_sel_pll == 0 && ind == 1, "R2 main kept during wait", clk_sel_pll, 0);
    tick(STAB);
    chk(clk_sel_pll == 1 && ind == 0, "R3 on PLL after wait", clk_sel_pll, 1);
    chk(act_mult == code[1:0], "R3 multiplier code mapping", act_mult, code);
  endtask

  task automatic back_main(input int code);
    wr(1, code, 0);
    tick(5);
    chk(clk_sel_pll == 1 && ind == 0, "R4 held until strobe", clk_sel_pll, 1);
    strobe();
    chk(clk_sel_pll == 0 && ind == 1, "R4 main after strobe", clk_sel_pll, 0);
  endtask

  initial begin
    tick(3);
    rst = 0;
    tick(1);
    chk(sel == 1 && ind == 1 && clk_sel_pll == 0, "R1 reset state", {sel, ind, clk_sel_pll}, 3'b110);
    chk(act_mult == 0 && mult_code == 0, "R1 reset multiplier", act_mult, 0);

    for (int c = 0; c < 4; c++) begin
      go_pll(c);
      back_main(c);
    end

    // R6: code write while on PLL is deferred
    go_pll(1);
    wr(0, 3, 0);
    tick(2);
    chk(act_mult == 1, "R6 no change on PLL", act_mult, 1);
    back_main(3);
    chk(act_mult == 1, "R6 held after return", act_mult, 1);
    wr(0, 3, 0);
    tick(STAB + 3);
    chk(act_mult == 3, "R6 new code latched at entry", act_mult, 3);

    // R5: watchdog event beats a concurrent write
    @(negedge clk); wdt = 1; wr_en = 1; wr_sel = 0; wr_mult = 3;
    @(negedge clk); wdt = 0; wr_en = 0;
    chk(sel == 1, "R5 watchdog forces main request", sel, 1);
    tick(3);
    chk(clk_sel_pll == 1, "R5 return waits for strobe", clk_sel_pll, 1);
    strobe();
    chk(ind == 1, "R5 back on main", ind, 1);

    // R5: standby event
    go_pll(2);
    @(negedge clk); sby = 1;
    @(negedge clk); sby = 0;
    chk(sel == 1, "R5 standby forces main request", sel, 1);
    tick(2); strobe();
    chk(ind == 1, "R5 standby back on main", ind, 1);

    // R7: abort during wait
    wr(0, 2, 0);
    tick(4);
    wr(1, 2, 0);
    tick(STAB + 4);
    chk(clk_sel_pll == 0 && ind == 1, "R7 aborted wait stays main", clk_sel_pll, 0);

    // R8: indication writes ignored
    wr(1, 0, 0);
    tick(1);
    chk(ind == 1, "R8 write 0 to indication on main", ind, 1);
    go_pll(1);
    wr(0, 1, 1);
    tick(1);
    chk(ind == 0, "R8 write 1 to indication on PLL", ind, 0);
    back_main(1);

    // random traffic with free-running sync strobe, reference model compares each cycle
    free_en = 1;
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      wr_en = ($urandom_range(0, 19) == 0);
      wr_sel = $urandom_range(0, 2) == 0;
      wr_mult = 2'($urandom_range(0, 3));
      wr_ind = 1'($urandom_range(0, 1));
      sby = ($urandom_range(0, 199) == 0);
      wdt = ($urandom_range(0, 199) == 0);
    end
    @(negedge clk);
    wr_en = 0; sby = 0; wdt = 0;
    tick(4);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule